// File: doc/BRIEF.md
# Calendar Real-Time Clock with Masked Alarm

This block is a bus-attached calendar clock. An internal prescaler divides the bus clock down to a one-second tick. Each tick advances a chain of eight counters: second, minute, hour, day of month, day of week, day of year, month and year. Each counter carries into the next one when it wraps. Software can write any counter on its own. It can also read the whole time through three packed words that pack several fields each.

A bank of eight alarm compare registers pairs with an 8-bit ignore mask. The alarm fires on the first tick after which every field that is not ignored equals its compare value. A second 8-bit enable set raises an increment flag whenever a selected field changes on a tick. The two flags sit in a flag register that software clears by writing 1 to a bit. A single registered interrupt line is the OR of the two flags. A control register runs the clock and can hold the prescaler in reset. A trim register only stores the value written to it.

Top module: `cal_rtc`

## Requirements
- R1: While control bit 0 is 1 and control bit 1 is 0, a tick occurs every TICK_DIV bus cycles, and the first tick lands TICK_DIV+1 cycles after the control write. If bit 0 is 0 or bit 1 is 1, the prescaler is cleared and no tick occurs.
- R2: On a tick, seconds advance. Seconds at 59 (or above) wrap to 0 and carry into minutes. Minutes at 59 wrap to 0 and carry into hours. Hours at 23 wrap to 0 and carry into the day fields.
- R3: A day carry steps day of week (6 wraps to 0) and day of year. Day of month goes to 1 once it has reached the month length, and otherwise steps by one. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when year mod 4 is 0 and 28 otherwise. Every other month has 31 days.
- R4: When day of month wraps in month 12 (or above), month returns to 1, year steps modulo 4096, and day of year becomes 1.
- R5: A write to a counter register at byte 0x20+4*i updates that field at once. The order is i = 0 second, 1 minute, 2 hour, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year. Field widths are 6, 6, 5, 5, 3, 12, 4 and 12 bits. A counter write drops a tick that falls in the same cycle.
- R6: Word 0x14 holds seconds in [5:0], minutes in [13:8], hours in [20:16] and day of week in [26:24]. Word 0x18 holds day of month in [4:0], month in [11:8] and year in [27:16]. Word 0x1C holds day of year in [11:0]. All other bits read 0.
- R7: Alarm registers sit at 0x60+4*i, in the same field order. Mask register 0x10 bit i set excludes field i from the compare. On a tick whose new time matches every unmasked field, flag bit 1 sets. A mask of 0xFF never sets it.
- R8: Register 0x0C bit i (same field order) selects field i. Flag bit 0 sets on a tick that changes a selected field. With 0x0C equal to 0 it never sets.
- R9: Flag register 0x00 clears each bit written as 1; a set in the same cycle wins. irq_o is 1 exactly when a flag bit is 1, and changes in the same cycle as the flags.
- R10: After reset, seconds, minutes, hours, day of week and year are 0; day of month, day of year and month are 1; mask 0x10 is 0xFF; registers 0x00, 0x08, 0x0C and 0x40 are 0; irq_o is 0. Control 0x08 keeps bits 0, 1 and 4. Trim register 0x40 keeps bits 17:0. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt, OR of the flags |

## Verification
The bench builds the clock with TICK_DIV = 4, so one second lasts four bus cycles. With the prescaler held in reset, the bench preloads counters to any instant, then pulses the enable to advance exactly one tick. This brings year-end, leap-day and month-length rollovers within a few dozen cycles instead of simulated days. Because the divider is small, the bench can also count the exact cycle of the first tick.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int NFLD = 8;
  localparam int FW   = 12;
  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DOM = 3;
  localparam int F_DOW = 4, F_DOY = 5, F_MON = 6, F_YEAR = 7;

  typedef logic [NFLD-1:0][FW-1:0] tvec_t;

  function automatic logic [FW-1:0] fld_mask(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1: return 12'h03F;
      3'd2, 3'd3: return 12'h01F;
      3'd4:       return 12'h007;
      3'd6:       return 12'h00F;
      default:    return 12'hFFF;
    endcase
  endfunction

  function automatic logic [FW-1:0] month_days(input logic [FW-1:0] mon,
                                               input logic [FW-1:0] yr);
    case (mon)
      12'd2:                       return (yr[1:0] == 2'b00) ? 12'd29 : 12'd28;
      12'd4, 12'd6, 12'd9, 12'd11: return 12'd30;
      default:                     return 12'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_rtc_prescale.sv
module cal_rtc_prescale #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  a_r1_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
  a_r1_halt: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !tick_o);
endmodule

// File: rtl/cal_rtc_time.sv
module cal_rtc_time
  import cal_rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [2:0]    wr_idx_i,
  input  logic [FW-1:0] wr_val_i,
  output tvec_t         now_o,
  output tvec_t         nxt_o,
  output logic [NFLD-1:0] chg_o
);
  tvec_t now_q, nx;
  logic  c_min, c_hr, c_day, dom_end, c_mon, c_yr;

  always_comb begin
    nx      = now_q;
    c_min   = now_q[F_SEC] >= 12'd59;
    nx[F_SEC] = c_min ? '0 : now_q[F_SEC] + 1'b1;
    c_hr    = c_min && (now_q[F_MIN] >= 12'd59);
    c_day   = c_hr && (now_q[F_HOUR] >= 12'd23);
    dom_end = now_q[F_DOM] >= month_days(now_q[F_MON], now_q[F_YEAR]);
    c_mon   = c_day && dom_end;
    c_yr    = c_mon && (now_q[F_MON] >= 12'd12);
    if (c_min) nx[F_MIN]  = c_hr ? '0 : now_q[F_MIN] + 1'b1;
    if (c_hr)  nx[F_HOUR] = c_day ? '0 : now_q[F_HOUR] + 1'b1;
    if (c_day) begin
      nx[F_DOW] = (now_q[F_DOW] >= 12'd6) ? '0 : now_q[F_DOW] + 1'b1;
      nx[F_DOY] = now_q[F_DOY] + 1'b1;
      nx[F_DOM] = dom_end ? 12'd1 : now_q[F_DOM] + 1'b1;
    end
    if (c_mon) nx[F_MON] = c_yr ? 12'd1 : now_q[F_MON] + 1'b1;
    if (c_yr) begin
      nx[F_YEAR] = now_q[F_YEAR] + 1'b1;
      nx[F_DOY]  = 12'd1;
    end
    for (int i = 0; i < NFLD; i++) nx[i] = nx[i] & fld_mask(3'(i));
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_chg
    assign chg_o[g] = (nx[g] != now_q[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q        <= '0;
      now_q[F_DOM] <= 12'd1;
      now_q[F_DOY] <= 12'd1;
      now_q[F_MON] <= 12'd1;
    end else if (wr_i) begin
      now_q[wr_idx_i] <= wr_val_i & fld_mask(wr_idx_i);
    end else if (tick_i) begin
      now_q <= nx;
    end
  end

  assign now_o = now_q;
  assign nxt_o = nx;

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !wr_i && now_q[F_SEC] == 12'd59) |=> (now_q[F_SEC] == 12'd0));
  a_r4_year_end: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !wr_i && now_q[F_MON] == 12'd12 && now_q[F_DOM] == 12'd31 &&
     now_q[F_HOUR] == 12'd23 && now_q[F_MIN] == 12'd59 && now_q[F_SEC] == 12'd59)
    |=> (now_q[F_MON] == 12'd1 && now_q[F_DOY] == 12'd1));
  a_r5_write_now: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (now_q[$past(wr_idx_i)] == ($past(wr_val_i) & fld_mask($past(wr_idx_i)))));
endmodule

// File: rtl/cal_rtc_match.sv
module cal_rtc_match
  import cal_rtc_pkg::*;
(
  input  tvec_t           cand_i,
  input  tvec_t           alarm_i,
  input  logic [NFLD-1:0] ign_i,
  output logic            hit_o
);
  logic [NFLD-1:0] eq;

  for (genvar g = 0; g < NFLD; g++) begin : g_cmp
    assign eq[g] = ign_i[g] || (cand_i[g] == alarm_i[g]);
  end

  assign hit_o = (&eq) && !(&ign_i);

  always_comb begin
    if (&ign_i) a_r7_all_masked: assert (!hit_o);
  end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  localparam int CAL_W = 18;

  logic              ccr_en, ccr_prst, ccr_caloff;
  logic [NFLD-1:0]   ciir_q, amr_q;
  logic [1:0]        ilr_q, ilr_d;
  logic [CAL_W-1:0]  cal_q;
  tvec_t             alm_q, now, nxt;
  logic [NFLD-1:0]   chg;
  logic              tick, hit, wr, cnt_wr, alm_wr, set_alm, set_inc;
  logic [4:0]        widx;
  logic              unused_bits;

  assign unused_bits = ^{bus_addr[1:0]};
  assign widx   = bus_addr[6:2];
  assign wr     = bus_sel && bus_wr;
  assign cnt_wr = wr && (bus_addr[6:5] == 2'b01);
  assign alm_wr = wr && (bus_addr[6:5] == 2'b11);

  cal_rtc_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .run_i(ccr_en && !ccr_prst), .tick_o(tick));

  cal_rtc_time u_time (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_i(cnt_wr),
    .wr_idx_i(bus_addr[4:2]), .wr_val_i(bus_wdata[FW-1:0]),
    .now_o(now), .nxt_o(nxt), .chg_o(chg));

  cal_rtc_match u_match (
    .cand_i(nxt), .alarm_i(alm_q), .ign_i(amr_q), .hit_o(hit));

  assign set_alm = tick && !cnt_wr && hit;
  assign set_inc = tick && !cnt_wr && |(chg & ciir_q);

  always_comb begin
    ilr_d = ilr_q;
    if (wr && widx == 5'd0) ilr_d = ilr_d & ~bus_wdata[1:0];
    ilr_d = ilr_d | {set_alm, set_inc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_en <= 1'b0; ccr_prst <= 1'b0; ccr_caloff <= 1'b0;
      ciir_q <= '0; amr_q <= '1; ilr_q <= '0; irq_o <= 1'b0;
      cal_q  <= '0; alm_q <= '0; bus_rdata <= '0;
    end else begin
      ilr_q <= ilr_d;
      irq_o <= |ilr_d;
      if (wr) begin
        case (widx)
          5'd2:  {ccr_caloff, ccr_prst, ccr_en} <= {bus_wdata[4], bus_wdata[1:0]};
          5'd3:  ciir_q <= bus_wdata[NFLD-1:0];
          5'd4:  amr_q  <= bus_wdata[NFLD-1:0];
          5'd16: cal_q  <= bus_wdata[CAL_W-1:0];
          default: ;
        endcase
      end
      if (alm_wr) alm_q[bus_addr[4:2]] <= bus_wdata[FW-1:0] & fld_mask(bus_addr[4:2]);
      if (bus_sel && !bus_wr) begin
        case (widx) inside
          5'd0:  bus_rdata <= {30'd0, ilr_q};
          5'd2:  bus_rdata <= {27'd0, ccr_caloff, 2'b00, ccr_prst, ccr_en};
          5'd3:  bus_rdata <= {24'd0, ciir_q};
          5'd4:  bus_rdata <= {24'd0, amr_q};
          5'd5:  bus_rdata <= {5'd0, now[F_DOW][2:0], 3'd0, now[F_HOUR][4:0],
                               2'd0, now[F_MIN][5:0], 2'd0, now[F_SEC][5:0]};
          5'd6:  bus_rdata <= {4'd0, now[F_YEAR], 4'd0, now[F_MON][3:0],
                               3'd0, now[F_DOM][4:0]};
          5'd7:  bus_rdata <= {20'd0, now[F_DOY]};
          [5'd8:5'd15]:  bus_rdata <= {20'd0, now[widx[2:0]]};
          5'd16: bus_rdata <= {14'd0, cal_q};
          [5'd24:5'd31]: bus_rdata <= {20'd0, alm_q[widx[2:0]]};
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  a_r7_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (amr_q == 8'hFF && !ilr_q[1]) |=> !ilr_q[1]);
  a_r8_inc_quiet: assert property (@(posedge clk) disable iff (rst)
    (ciir_q == 8'h00 && !ilr_q[0]) |=> !ilr_q[0]);
  a_r9_alarm_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(ilr_q[1]) |-> $past(tick));
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (ilr_q == 2'b00 && !tick) |=> !irq_o);
endmodule

// File: tb/cal_rtc_bench.sv
module cal_rtc_bench;
  localparam int DIV = 4;
  localparam logic [6:0] A_ILR = 7'h00, A_CCR = 7'h08, A_CIIR = 7'h0C, A_AMR = 7'h10;
  localparam logic [6:0] A_P0 = 7'h14, A_P1 = 7'h18, A_P2 = 7'h1C, A_CAL = 7'h40;

  logic clk = 0, rst = 1, bus_sel = 0, bus_wr = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o;
  int checks = 0, fails = 0;
  bit done = 0;
  int mt[8];
  int wid[8] = '{63, 63, 31, 31, 7, 4095, 15, 4095};

  always #2 clk = ~clk;

  cal_rtc #(.TICK_DIV(DIV)) u_cal_rtc (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bwr(input logic [6:0] a, input int d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [6:0] a, output int d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  // one tick with DIV = 4: enable, let one tick land, then hold the prescaler
  task automatic step_one();
    bwr(A_CCR, 1);
    repeat (5) @(negedge clk);
    bwr(A_CCR, 2);
  endtask

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    bit cm, ch, cd, cmo, cy;
    cm = mt[0] >= 59; ch = cm && mt[1] >= 59; cd = ch && mt[2] >= 23;
    cmo = cd && mt[3] >= mdays(mt[6], mt[7]); cy = cmo && mt[6] >= 12;
    mt[0] = cm ? 0 : mt[0] + 1;
    if (cm) mt[1] = ch ? 0 : mt[1] + 1;
    if (ch) mt[2] = cd ? 0 : mt[2] + 1;
    if (cd) begin
      mt[4] = (mt[4] >= 6) ? 0 : mt[4] + 1;
      mt[5] = (mt[5] + 1) & 4095;
      mt[3] = cmo ? 1 : mt[3] + 1;
    end
    if (cmo) mt[6] = cy ? 1 : mt[6] + 1;
    if (cy) begin mt[7] = (mt[7] + 1) & 4095; mt[5] = 1; end
  endtask

  task automatic load_time();
    for (int i = 0; i < 8; i++) bwr(7'(32 + 4 * i), mt[i]);
  endtask

  task automatic run_case(input string tag);
    int d;
    load_time();
    model_step();
    step_one();
    for (int i = 0; i < 8; i++) begin
      brd(7'(32 + 4 * i), d);
      chk($sformatf("R2 R3 R4 %s field %0d", tag, i), d, mt[i]);
    end
    brd(A_P0, d);
    chk({"R6 word0 ", tag}, d, (mt[4] << 24) | (mt[2] << 16) | (mt[1] << 8) | mt[0]);
    brd(A_P1, d);
    chk({"R6 word1 ", tag}, d, (mt[7] << 16) | (mt[6] << 8) | mt[3]);
    brd(A_P2, d);
    chk({"R6 word2 ", tag}, d, mt[5]);
  endtask

  task automatic set_mt(input int s, input int mi, input int h, input int dm,
                        input int dw, input int dy, input int mo, input int y);
    mt = '{s, mi, h, dm, dw, dy, mo, y};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int d;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 irq", int'(irq_o), 0);
    brd(A_ILR, d);  chk("R10 flags", d, 0);
    brd(A_CCR, d);  chk("R10 control", d, 0);
    brd(A_CIIR, d); chk("R10 incr enable", d, 0);
    brd(A_AMR, d);  chk("R10 mask", d, 8'hFF);
    brd(A_P0, d);   chk("R10 word0", d, 0);
    brd(A_P1, d);   chk("R10 word1", d, 1 | (1 << 8));
    brd(A_P2, d);   chk("R10 word2", d, 1);
    bwr(A_CAL, 32'hFFFF_FFFF); brd(A_CAL, d); chk("R10 trim width", d, 32'h3FFFF);
    bwr(A_CCR, 32'h13); brd(A_CCR, d); chk("R10 control bits", d, 32'h13);
    bwr(A_CCR, 2);
    // R5 immediate writes and width masks
    bwr(7'h20, 42); brd(7'h20, d); chk("R5 second write", d, 42);
    bwr(7'h3C, 32'h1ABC); brd(7'h3C, d); chk("R5 year width", d, 32'hABC);
    bwr(7'h30, 15); brd(7'h30, d); chk("R5 dow width", d, 7);
    // R1 first tick timing via second increment flag
    bwr(A_CIIR, 1); bwr(A_ILR, 3);
    bwr(A_CCR, 1);
    repeat (4) @(negedge clk);
    chk("R1 no tick before period", int'(irq_o), 0);
    @(negedge clk);
    chk("R1 tick at period", int'(irq_o), 1);
    bwr(A_CCR, 2); bwr(A_ILR, 3);
    // R1 prescaler reset and disable hold the clock
    bwr(7'h20, 10);
    bwr(A_CCR, 3); repeat (20) @(negedge clk);
    bwr(A_CCR, 0); repeat (20) @(negedge clk);
    bwr(A_CCR, 2);
    brd(7'h20, d); chk("R1 held seconds", d, 10);
    brd(A_ILR, d); chk("R1 held flags", d, 0);
    bwr(A_CIIR, 0);
    // directed rollovers
    set_mt(59, 59, 23, 28, 3, 59, 2, 2024);  run_case("leap feb 28");
    set_mt(59, 59, 23, 28, 3, 59, 2, 2023);  run_case("plain feb 28");
    set_mt(59, 59, 23, 31, 6, 365, 12, 99);  run_case("year end");
    set_mt(59, 59, 23, 31, 0, 400, 12, 4095); run_case("year wrap");
    set_mt(59, 59, 23, 30, 2, 120, 4, 7);    run_case("april end");
    set_mt(59, 58, 22, 5, 1, 5, 1, 0);       run_case("minute carry");
    // random times biased to rollovers
    for (int k = 0; k < 30; k++) begin
      int mo, y;
      mo = $urandom_range(12, 1); y = $urandom_range(4095, 0);
      set_mt(($urandom_range(2, 0) == 0) ? $urandom_range(58, 0) : 59,
             ($urandom_range(1, 0) == 0) ? $urandom_range(58, 0) : 59,
             ($urandom_range(1, 0) == 0) ? $urandom_range(22, 0) : 23,
             ($urandom_range(1, 0) == 0) ? $urandom_range(mdays(mo, y), 1) : mdays(mo, y),
             $urandom_range(6, 0), $urandom_range(366, 1), mo, y);
      run_case($sformatf("random %0d", k));
    end
    // R7 alarm compare under mask
    set_mt(30, 20, 10, 5, 2, 36, 2, 100); load_time();
    bwr(7'h60, 31); bwr(7'h64, 13); bwr(A_AMR, 32'hFE);
    step_one();
    brd(A_ILR, d); chk("R7 seconds-only match", d, 2);
    chk("R9 irq on alarm", int'(irq_o), 1);
    bwr(A_ILR, 2);
    brd(A_ILR, d); chk("R9 clear alarm flag", d, 0);
    chk("R9 irq after clear", int'(irq_o), 0);
    bwr(A_AMR, 32'hFC); bwr(7'h20, 30); step_one();
    brd(A_ILR, d); chk("R7 minute mismatch", d, 0);
    bwr(7'h64, 20); bwr(7'h20, 30); step_one();
    brd(A_ILR, d); chk("R7 minute match", d, 2);
    bwr(A_ILR, 2); bwr(A_AMR, 32'hFF); bwr(7'h20, 30); step_one();
    brd(A_ILR, d); chk("R7 fully masked", d, 0);
    chk("R7 irq stays low", int'(irq_o), 0);
    // R8 increment flag
    bwr(A_CIIR, 2); bwr(7'h20, 58); step_one();
    brd(A_ILR, d); chk("R8 minute unchanged", d, 0);
    step_one();
    brd(A_ILR, d); chk("R8 minute changed", d, 1);
    chk("R9 irq on increment", int'(irq_o), 1);
    bwr(A_ILR, 1);
    brd(A_ILR, d); chk("R9 clear increment flag", d, 0);
    bwr(A_CIIR, 0); bwr(7'h20, 59); step_one();
    brd(A_ILR, d); chk("R8 no fields selected", d, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule